// File: doc/BRIEF.md
# TLB Fill and Replacement Controller

This block holds a fully associative translation buffer of 64 entries, each made of a 64-bit tag word and a 64-bit translation word. It takes care of putting new translations into the array and of reading entries back. Lookup, demapping and the control registers live elsewhere; this block only places, replaces and exposes entries.

Two write operations share one request port. A fill finds its own victim: the lowest-numbered entry that is not valid or, if every entry is valid, the lowest-numbered entry that is not locked. If all entries are valid and locked, the fill is refused and a one-cycle failure pulse comes out. An indexed write puts the data at the entry that the address selects, whatever that entry holds. In both cases the tag written comes from the tag-access input. When the overwritten entry held a valid mapping, the block sends out a one-cycle flush request with the base address and byte size of the old page, so that cached translations of that page can be dropped.

A separate read port returns the tag or the translation word of an addressed entry one cycle after the request.

Top module: `tlb_refill_ctrl`

## Requirements
- R1: After synchronous reset every entry reads back as zero on both words, and `flush_vld`, `fill_fail` and `rd_data` are zero.
- R2: A fill (`op_vld`=1, `op_kind`=0) writes the lowest-index entry whose translation bit 63 (valid) is 0, with `tag_in` as its tag and `op_data` as its translation word.
- R3: When no entry has bit 63 clear, a fill writes the lowest-index entry whose translation bit 6 (lock) is 0.
- R4: When every entry has bits 63 and 6 both set, a fill writes nothing, and `fill_fail` is 1 for exactly the cycle after the request and no flush is requested.
- R5: An indexed write (`op_vld`=1, `op_kind`=1) writes entry `op_addr[8:3]` with `tag_in` and `op_data`, whether or not that entry is locked or valid; the other address bits are ignored.
- R6: A read (`rd_en`=1) of entry `rd_addr[8:3]` places the translation word (`rd_tte`=1) or the tag word (`rd_tte`=0) on `rd_data` after the next clock edge; a write on that same edge is not yet visible to that read.
- R7: When a write or fill overwrites an entry whose old bit 63 is 1, `flush_vld` is 1 for the cycle after the request, with `flush_size` = 8192 << (3 * old bits 62:61) and `flush_base` = old tag AND NOT (`flush_size` - 1).
- R8: When the overwritten entry had bit 63 clear, `flush_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Write request valid |
| op_kind | input | 1 | 0 = fill with automatic victim, 1 = indexed write |
| op_addr | input | 64 | Address of indexed write; bits 8:3 select the entry |
| op_data | input | 64 | Translation word to write |
| tag_in | input | 64 | Tag-access value written as the entry tag |
| rd_en | input | 1 | Read request |
| rd_tte | input | 1 | 1 = read translation word, 0 = read tag |
| rd_addr | input | 64 | Read address; bits 8:3 select the entry |
| rd_data | output | 64 | Registered read data |
| flush_vld | output | 1 | One-cycle flush request |
| flush_base | output | 64 | Base address of the page to flush |
| flush_size | output | 64 | Byte size of the page to flush |
| fill_fail | output | 1 | One-cycle pulse: fill found no victim |

## Verification
A write or fill and a read of the same entry can land on one clock edge; the read must then return the contents from before the write, while the flush pulse reports the old mapping that the same edge throws away. The bench provokes this by aiming half of its random reads at the entry the concurrent request will overwrite, computing that victim itself from a model of the array. It judges the read data, the flush base and size and the failure pulse against that model's state before the edge, and then applies the write to the model.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;

    localparam int unsigned TLBR_DW    = 64;
    localparam int unsigned VALID_BIT  = 63;
    localparam int unsigned LOCK_BIT   = 6;
    localparam int unsigned PS_LSB     = 61;
    localparam int unsigned PAGE_SHIFT = 13;

    typedef enum logic {
        OP_FILL  = 1'b0,
        OP_WRITE = 1'b1
    } tlbr_op_e;

    typedef struct packed {
        logic [TLBR_DW-1:0] tag;
        logic [TLBR_DW-1:0] tte;
    } tlbr_entry_t;

    typedef struct packed {
        logic [TLBR_DW-1:0] base;
        logic [TLBR_DW-1:0] size;
    } tlbr_flush_t;

    function automatic logic [TLBR_DW-1:0] page_mask(input logic [1:0] ps);
        return {TLBR_DW{1'b1}} << (PAGE_SHIFT + 3 * int'(ps));
    endfunction

endpackage

// File: rtl/tlbr_victim.sv
module tlbr_victim #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] lock_vec,
    output logic               inv_hit,
    output logic [IDX_W-1:0]   inv_idx,
    output logic               unl_hit,
    output logic [IDX_W-1:0]   unl_idx
);
    // Descending scan: the last assignment wins, so the lowest index is kept.
    always_comb begin
        inv_hit = 1'b0;
        inv_idx = '0;
        unl_hit = 1'b0;
        unl_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                inv_hit = 1'b1;
                inv_idx = IDX_W'(i);
            end
            if (!lock_vec[i]) begin
                unl_hit = 1'b1;
                unl_idx = IDX_W'(i);
            end
        end
    end

    logic [ENTRIES-1:0] below_inv, below_unl;
    assign below_inv = (ENTRIES'(1) << inv_idx) - ENTRIES'(1);
    assign below_unl = (ENTRIES'(1) << unl_idx) - ENTRIES'(1);

    // R2: chosen free slot is clear and all slots beneath it are in use
    p_inv_lowest_r2: assert property (@(posedge clk) disable iff (rst)
        inv_hit |-> (!valid_vec[inv_idx] && ((~valid_vec & below_inv) == '0)));

    // R3: chosen unlocked slot is unlocked and all beneath are locked
    p_unl_lowest_r3: assert property (@(posedge clk) disable iff (rst)
        unl_hit |-> (!lock_vec[unl_idx] && ((~lock_vec & below_unl) == '0)));

endmodule

// File: rtl/tlbr_store.sv
module tlbr_store
    import tlbr_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  tlbr_entry_t        wentry,
    output tlbr_entry_t        old_entry,
    input  logic               rd_en,
    input  logic               rd_tte,
    input  logic [IDX_W-1:0]   ridx,
    output logic [TLBR_DW-1:0] rd_data,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] lock_vec
);
    tlbr_entry_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wentry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_tte ? mem[ridx].tte : mem[ridx].tag;
    end

    assign old_entry = mem[widx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
        assign valid_vec[g] = mem[g].tte[VALID_BIT];
        assign lock_vec[g]  = mem[g].tte[LOCK_BIT];
    end

    // R5: a write request lands in the addressed slot on the next edge
    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(widx)] == $past(wentry)));

endmodule

// File: rtl/tlbr_flush.sv
module tlbr_flush
    import tlbr_pkg::*;
(
    input  tlbr_entry_t old_entry,
    output tlbr_flush_t req
);
    logic [TLBR_DW-1:0] mask;

    assign mask     = page_mask(old_entry.tte[PS_LSB +: 2]);
    assign req.base = old_entry.tag & mask;
    assign req.size = ~mask + TLBR_DW'(1);

endmodule

// File: rtl/tlb_refill_ctrl.sv
module tlb_refill_ctrl
    import tlbr_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_LSB = 3,
    parameter int unsigned ADDR_W  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_vld,
    input  logic               op_kind,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [TLBR_DW-1:0] op_data,
    input  logic [TLBR_DW-1:0] tag_in,
    input  logic               rd_en,
    input  logic               rd_tte,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [TLBR_DW-1:0] rd_data,
    output logic               flush_vld,
    output logic [TLBR_DW-1:0] flush_base,
    output logic [TLBR_DW-1:0] flush_size,
    output logic               fill_fail
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    tlbr_op_e           kind;
    logic               is_fill, is_wr;
    logic [ENTRIES-1:0] valid_vec, lock_vec;
    logic               inv_hit, unl_hit, fill_ok, we;
    logic [IDX_W-1:0]   inv_idx, unl_idx, widx;
    tlbr_entry_t        old_entry, wentry;
    tlbr_flush_t        flush_d;

    assign kind    = tlbr_op_e'(op_kind);
    assign is_fill = op_vld && (kind == OP_FILL);
    assign is_wr   = op_vld && (kind == OP_WRITE);

    tlbr_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .lock_vec  (lock_vec),
        .inv_hit   (inv_hit),
        .inv_idx   (inv_idx),
        .unl_hit   (unl_hit),
        .unl_idx   (unl_idx)
    );

    assign fill_ok    = inv_hit || unl_hit;
    assign widx       = is_fill ? (inv_hit ? inv_idx : unl_idx)
                                : op_addr[IDX_LSB +: IDX_W];
    assign we         = is_wr || (is_fill && fill_ok);
    assign wentry.tag = tag_in;
    assign wentry.tte = op_data;

    tlbr_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (we),
        .widx      (widx),
        .wentry    (wentry),
        .old_entry (old_entry),
        .rd_en     (rd_en),
        .rd_tte    (rd_tte),
        .ridx      (rd_addr[IDX_LSB +: IDX_W]),
        .rd_data   (rd_data),
        .valid_vec (valid_vec),
        .lock_vec  (lock_vec)
    );

    tlbr_flush u_flush (
        .old_entry (old_entry),
        .req       (flush_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_vld  <= 1'b0;
            flush_base <= '0;
            flush_size <= '0;
            fill_fail  <= 1'b0;
        end else begin
            flush_vld <= we && old_entry.tte[VALID_BIT];
            fill_fail <= is_fill && !fill_ok;
            if (we && old_entry.tte[VALID_BIT]) begin
                flush_base <= flush_d.base;
                flush_size <= flush_d.size;
            end
        end
    end

    // R4: a refused fill never reports a flush
    p_fail_no_flush_r4: assert property (@(posedge clk) disable iff (rst)
        fill_fail |-> !flush_vld);

    // R4: a fill into a fully valid and locked array is refused
    p_fail_when_full_r4: assert property (@(posedge clk) disable iff (rst)
        (is_fill && ((valid_vec & lock_vec) == '1)) |=> fill_fail);

    // R7: flush range is a power-of-two size with an aligned base
    p_flush_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        flush_vld |-> (($countones(flush_size) == 1) &&
                       ((flush_base & (flush_size - TLBR_DW'(1))) == '0)));

    // R8: a fill that takes a free slot asks for no flush
    p_free_no_flush_r8: assert property (@(posedge clk) disable iff (rst)
        (is_fill && inv_hit) |=> !flush_vld);

endmodule

// File: tb/sim_tlb_refill_ctrl.sv
module sim_tlb_refill_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_vld = 1'b0, op_kind = 1'b0, rd_en = 1'b0, rd_tte = 1'b0;
    logic [63:0] op_addr = '0, op_data = '0, tag_in = '0, rd_addr = '0;
    logic [63:0] rd_data, flush_base, flush_size;
    logic        flush_vld, fill_fail;

    always #4 clk = ~clk;

    tlb_refill_ctrl u0 (
        .clk(clk), .rst(rst), .op_vld(op_vld), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .tag_in(tag_in),
        .rd_en(rd_en), .rd_tte(rd_tte), .rd_addr(rd_addr), .rd_data(rd_data),
        .flush_vld(flush_vld), .flush_base(flush_base),
        .flush_size(flush_size), .fill_fail(fill_fail)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [63:0] mtag [64];
    logic [63:0] mtte [64];

    task automatic chk(string lbl, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    function automatic int pick_victim();
        for (int i = 0; i < 64; i++) if (!mtte[i][63]) return i;
        for (int i = 0; i < 64; i++) if (!mtte[i][6]) return i;
        return -1;
    endfunction

    function automatic logic [63:0] mk_addr(int idx);
        logic [63:0] a;
        a = {$urandom, $urandom};
        a[8:3] = 6'(idx);
        return a;
    endfunction

    function automatic logic [63:0] mk_tte(bit v, bit l, logic [1:0] ps);
        logic [63:0] t;
        t = {$urandom, $urandom};
        t[63] = v;
        t[62:61] = ps;
        t[6] = l;
        return t;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(bit v, bit k, int idx, logic [63:0] d, logic [63:0] t,
                        bit re, int ridx, bit rs, string lbl);
        int          tgt;
        bit          exp_fail, exp_flush;
        logic [63:0] exp_base, exp_size, exp_rd, m;
        op_vld  = v;
        op_kind = k;
        op_addr = mk_addr(idx);
        op_data = d;
        tag_in  = t;
        rd_en   = re;
        rd_tte  = rs;
        rd_addr = mk_addr(ridx);
        tgt = -1;
        if (v) tgt = k ? idx : pick_victim();
        exp_fail  = v && !k && (tgt < 0);
        exp_flush = (tgt >= 0) && mtte[tgt][63];
        exp_base = '0;
        exp_size = '0;
        if (exp_flush) begin
            m = 64'hFFFF_FFFF_FFFF_E000 << (3 * int'(mtte[tgt][62:61]));
            exp_size = ~m + 64'd1;
            exp_base = mtag[tgt] & m;
        end
        exp_rd = rs ? mtte[ridx] : mtag[ridx];
        @(negedge clk);
        chk({lbl, " R4 fill_fail"}, {63'd0, fill_fail}, {63'd0, exp_fail});
        chk({lbl, exp_flush ? " R7 flush_vld" : " R8 flush_vld"},
            {63'd0, flush_vld}, {63'd0, exp_flush});
        if (exp_flush) begin
            chk({lbl, " R7 flush_base"}, flush_base, exp_base);
            chk({lbl, " R7 flush_size"}, flush_size, exp_size);
        end
        if (re) chk({lbl, " R6 rd_data"}, rd_data, exp_rd);
        if (tgt >= 0) begin
            mtag[tgt] = t;
            mtte[tgt] = d;
        end
        op_vld = 1'b0;
        rd_en  = 1'b0;
    endtask

    task automatic rd_check(int idx, string lbl);
        step(0, 0, 0, '0, '0, 1, idx, 1, {lbl, " tte"});
        step(0, 0, 0, '0, '0, 1, idx, 0, {lbl, " tag"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 64; i++) begin
            mtag[i] = '0;
            mtte[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 rd_data after reset", rd_data, '0);
        chk("R1 flush_vld after reset", {63'd0, flush_vld}, '0);
        chk("R1 fill_fail after reset", {63'd0, fill_fail}, '0);
        rd_check(0, "R1 entry 0");
        rd_check(63, "R1 entry 63");

        // R2 / R8: fills into an empty array go to 0, 1, 2 without flush
        for (int i = 0; i < 3; i++)
            step(1, 0, 0, mk_tte(1, 0, 2'(i)), {$urandom, $urandom},
                 0, 0, 0, "R2 fill empty");
        rd_check(2, "R2 third fill at entry 2");

        // R5 / R6 / R7: indexed write over valid entry 1, same-cycle read
        step(1, 1, 1, mk_tte(1, 1, 2'd3), {$urandom, $urandom},
             1, 1, 1, "R5 write over valid");
        rd_check(1, "R5 entry 1 after write");

        // R8 then R2: invalidate entry 0, refill picks it
        step(1, 1, 0, 64'd0, 64'd0, 0, 0, 0, "R5 invalidate 0");
        step(1, 0, 0, mk_tte(1, 0, 2'd1), {$urandom, $urandom},
             1, 0, 0, "R2 refill lowest free");
        rd_check(0, "R2 entry 0 refilled");

        // R4: fill everything locked, then a fill must fail
        for (int i = 0; i < 64; i++)
            step(1, 1, i, mk_tte(1, 1, 2'($urandom)), {$urandom, $urandom},
                 0, 0, 0, "R5 lock all");
        step(1, 0, 0, mk_tte(1, 0, 2'd0), {$urandom, $urandom},
             1, 5, 1, "R4 full and locked");
        rd_check(5, "R4 unchanged after refused fill");

        // R3: unlock entry 37 and 50; fill replaces 37 with a flush
        step(1, 1, 50, mk_tte(1, 0, 2'd2), {$urandom, $urandom}, 0, 0, 0, "R5 unlock 50");
        step(1, 1, 37, mk_tte(1, 0, 2'd3), {$urandom, $urandom}, 0, 0, 0, "R5 unlock 37");
        step(1, 0, 0, mk_tte(1, 1, 2'd0), {$urandom, $urandom},
             1, 37, 0, "R3 lowest unlocked");
        rd_check(37, "R3 entry 37 replaced");
        rd_check(50, "R3 entry 50 untouched");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            bit          v, k, rs, re;
            int          idx, ridx, tgt;
            logic [63:0] d;
            v   = ($urandom % 4) != 0;
            k   = ($urandom % 2) != 0;
            idx = int'($urandom % 64);
            d   = mk_tte(($urandom % 4) != 0, ($urandom % 3) == 0, 2'($urandom));
            tgt = (v && k) ? idx : pick_victim();
            re  = ($urandom % 3) != 0;
            rs  = ($urandom % 2) != 0;
            ridx = (($urandom % 2) != 0 && tgt >= 0) ? tgt : int'($urandom % 64);
            step(v, k, idx, d, {$urandom, $urandom}, re, ridx, rs,
                 k ? "R5 random write" : "R2 R3 random fill");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule